// File: doc/BRIEF.md
# USB Host List Service Scheduler

This block sits inside a USB host controller and decides, for every frame, which endpoint-descriptor list the descriptor fetch engine should walk next. At the start of a frame it first serves the periodic list, if periodic work was enabled at that moment. After that it interleaves the control and bulk lists by a programmable weight. The weight counts only control descriptors that actually carried work.

Each decision appears as a list-select code together with a one-cycle request strobe. The fetch engine answers every request with a service-done handshake. That handshake tells the scheduler whether a serviced control descriptor was non-empty, and whether a periodic descriptor was the last one in its list. If periodic work is still unfinished when the frame ends, the block counts a scheduling overrun and raises a sticky status flag, which software clears with a strobe.

Top module: `usbh_list_sched`

## Requirements
- R1: While reset is asserted and right after it, list_sel_o is 2'b00 (idle), req_o is 0, ovr_cnt_o is 0 and ovr_flag_o is 0.
- R2: The periodic-enable input is sampled only on a start-of-frame pulse. When it is 1 there, the first request of the frame selects the periodic list (list_sel_o = 2'b01). When it is 0 there, no periodic request is made in that frame. A change in the middle of a frame has no effect until the next start-of-frame.
- R3: A service-done carrying the last-periodic mark ends periodic work for the frame. The next request then goes to control (2'b10) or bulk (2'b11).
- R4: The control-to-bulk ratio field is 2 bits. Its value is sampled at start-of-frame: 00 = 1:1, 01 = 2:1, 10 = 3:1, 11 = 4:1. After value+1 non-empty control descriptors, one bulk descriptor is requested.
- R5: A control descriptor whose service-done reports it as empty does not count toward the ratio, and control requests continue.
- R6: After one bulk descriptor the scheduler returns to control. The ratio count restarts from zero on every switch to bulk and on every start-of-frame.
- R7: A disabled control or bulk list is never selected. When the control list is reported empty, bulk is chosen directly. When neither list can be served, the scheduler stays idle with no requests until the next start-of-frame.
- R8: If the periodic list is still being processed when end-of-frame arrives, ovr_cnt_o increments modulo 4, ovr_flag_o is set, and the scheduler goes idle until the next start-of-frame. An end-of-frame with no periodic work pending changes neither value.
- R9: ovr_flag_o stays set until ovr_clr_i is pulsed, and it is cleared on the following cycle. When a clear and a new overrun fall on the same cycle, the flag stays set. ovr_cnt_o is cleared only by reset.
- R10: req_o is high for a single cycle per descriptor, with a valid non-idle list_sel_o. Exactly one new request follows each service-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| per_en_i | input | 1 | Periodic list enable, sampled at start-of-frame |
| ctl_en_i | input | 1 | Control list enable |
| blk_en_i | input | 1 | Bulk list enable |
| ctl_empty_i | input | 1 | Control list currently holds no descriptors |
| ratio_i | input | 2 | Control-to-bulk ratio code |
| svc_done_i | input | 1 | Service of the requested descriptor finished |
| svc_nonempty_i | input | 1 | With svc_done_i: the control descriptor carried work |
| per_last_i | input | 1 | With svc_done_i: last descriptor of the periodic list |
| ovr_clr_i | input | 1 | Clear strobe for the overrun flag |
| req_o | output | 1 | Descriptor request strobe to the fetch engine |
| list_sel_o | output | 2 | 00 idle, 01 periodic, 10 control, 11 bulk |
| ovr_cnt_o | output | 2 | Scheduling overrun counter |
| ovr_flag_o | output | 1 | Sticky overrun status |

## Verification
A start-of-frame pulse sampled at a clock edge produces a request with its list code before the next edge. A service-done seen at an edge produces the following request in the same way. End-of-frame and clear strobes show their effect on the counter and flag one edge later. The bench drives every input at the falling edge and samples there, so each result is read exactly one rising edge after its cause. A monitor pops the expected list code from a scoreboard queue for every request strobe it sees. Direct checks read the idle code, the counter and the flag one cycle after each frame strobe.

// File: rtl/usbh_sched_pkg.sv
package usbh_sched_pkg;

  typedef enum logic [1:0] {
    LIST_IDLE = 2'b00,
    LIST_PER  = 2'b01,
    LIST_CTL  = 2'b10,
    LIST_BLK  = 2'b11
  } list_e;

  // Choose between control and bulk once periodic work is over.
  function automatic list_e pick_list(input logic ctl_ok,
                                      input logic blk_ok,
                                      input logic quota_hit);
    if (ctl_ok && !(quota_hit && blk_ok)) return LIST_CTL;
    else if (blk_ok)                      return LIST_BLK;
    else                                  return LIST_IDLE;
  endfunction

endpackage

// File: rtl/usbh_sched_quota.sv
module usbh_sched_quota #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [RATIO_W-1:0] ratio,
  output logic               hit
);
  localparam int CNT_W = $clog2((1 << RATIO_W) + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n, lim;

  assign lim = CNT_W'(ratio) + CNT_W'(1);
  assign hit = (cnt_q + CNT_W'(1)) == lim;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)       cnt_n = '0;
    else if (step) cnt_n = hit ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/usbh_sched_ovr.sv
module usbh_sched_ovr #(
  parameter int OVR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic [OVR_W-1:0] cnt,
  output logic             flag
);
  logic [OVR_W-1:0] cnt_q, cnt_n;
  logic             flag_q, flag_n;

  always_comb begin
    cnt_n  = evt ? cnt_q + OVR_W'(1) : cnt_q;
    flag_n = evt ? 1'b1 : (clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/usbh_list_sched.sv
module usbh_list_sched
  import usbh_sched_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int OVR_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               per_en_i,
  input  logic               ctl_en_i,
  input  logic               blk_en_i,
  input  logic               ctl_empty_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               svc_done_i,
  input  logic               svc_nonempty_i,
  input  logic               per_last_i,
  input  logic               ovr_clr_i,
  output logic               req_o,
  output logic [1:0]         list_sel_o,
  output logic [OVR_W-1:0]   ovr_cnt_o,
  output logic               ovr_flag_o
);
  list_e              state_q, state_n;
  logic               pend_q, pend_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n;
  logic               ctl_ok, done_fire, ctl_step, quota_hit, ovr_evt;

  assign ctl_ok    = ctl_en_i && !ctl_empty_i;
  assign done_fire = pend_q && svc_done_i;
  assign ctl_step  = done_fire && (state_q == LIST_CTL) && svc_nonempty_i && !sof_i;
  assign ovr_evt   = eof_i && (state_q == LIST_PER);

  usbh_sched_quota #(.RATIO_W(RATIO_W)) i_quota (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sof_i),
    .step  (ctl_step),
    .ratio (ratio_q),
    .hit   (quota_hit)
  );

  usbh_sched_ovr #(.OVR_W(OVR_W)) i_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (ovr_evt),
    .clr   (ovr_clr_i),
    .cnt   (ovr_cnt_o),
    .flag  (ovr_flag_o)
  );

  // Next-state logic
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    ratio_n = ratio_q;
    if (sof_i) begin
      ratio_n = ratio_i;
      pend_n  = 1'b0;
      state_n = per_en_i ? LIST_PER : pick_list(ctl_ok, blk_en_i, 1'b0);
    end else if (ovr_evt) begin
      pend_n  = 1'b0;
      state_n = LIST_IDLE;
    end else begin
      if (req_o) pend_n = 1'b1;
      if (done_fire) begin
        pend_n = 1'b0;
        unique case (state_q)
          LIST_PER: if (per_last_i) state_n = pick_list(ctl_ok, blk_en_i, 1'b0);
          LIST_CTL: state_n = pick_list(ctl_ok, blk_en_i, ctl_step && quota_hit);
          LIST_BLK: state_n = pick_list(ctl_ok, blk_en_i, 1'b0);
          default:  state_n = LIST_IDLE;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LIST_IDLE;
      pend_q  <= 1'b0;
      ratio_q <= '0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      ratio_q <= ratio_n;
    end
  end

  assign req_o      = (state_q != LIST_IDLE) && !pend_q;
  assign list_sel_o = state_q;
endmodule

// File: rtl/usbh_list_sched_chk.sv
module usbh_list_sched_chk #(
  parameter int OVR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof_i,
  input logic             eof_i,
  input logic             blk_en_i,
  input logic             ovr_clr_i,
  input logic             req_o,
  input logic [1:0]       list_sel_o,
  input logic [OVR_W-1:0] ovr_cnt_o,
  input logic             ovr_flag_o
);
  // R10: a request always names a real list
  assert_req_has_list_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> list_sel_o != 2'b00);

  // R10: a strobe lasts one cycle unless a new frame restarts it
  assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !sof_i) |=> !req_o);

  // R2: periodic selection only begins at a frame start
  assert_per_at_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (list_sel_o == 2'b01 && $past(list_sel_o) != 2'b01) |-> $past(sof_i));

  // R7: bulk is entered only while bulk is enabled
  assert_blk_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (list_sel_o == 2'b11 && $past(list_sel_o) != 2'b11) |-> $past(blk_en_i));

  // R8: the counter moves only after an end-of-frame, by one step
  assert_cnt_on_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_cnt_o) |-> ($past(eof_i) && ovr_cnt_o == OVR_W'($past(ovr_cnt_o) + 1'b1)));

  // R8: leaving periodic through end-of-frame goes idle
  assert_eof_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (list_sel_o == 2'b01 && eof_i && !sof_i) |=> list_sel_o == 2'b00);

  // R9: the flag drops only after a clear strobe
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag_o) |-> $past(ovr_clr_i));
endmodule

bind usbh_list_sched usbh_list_sched_chk #(.OVR_W(OVR_W)) i_chk (.*);

// File: tb/test_usbh_list_sched.sv
module test_usbh_list_sched;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_n, sof, eof, per_en, ctl_en, blk_en, ctl_empty;
  logic [1:0] ratio;
  logic svc_done, svc_nonempty, per_last, ovr_clr;
  logic req;
  logic [1:0] list_sel, ovr_cnt;
  logic ovr_flag;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_list_sched i_usbh_list_sched (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .eof_i(eof), .per_en_i(per_en),
    .ctl_en_i(ctl_en), .blk_en_i(blk_en), .ctl_empty_i(ctl_empty), .ratio_i(ratio),
    .svc_done_i(svc_done), .svc_nonempty_i(svc_nonempty), .per_last_i(per_last),
    .ovr_clr_i(ovr_clr), .req_o(req), .list_sel_o(list_sel),
    .ovr_cnt_o(ovr_cnt), .ovr_flag_o(ovr_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Scoreboard monitor: each request pops one expected list code
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req === 1'b1) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected request", list_sel, 0);
      else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(list_sel == e, t, list_sel, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_CYCLES) begin
      chk(0, "watchdog", cycles, WD_CYCLES);
      summary();
    end
  end

  task automatic push(input logic [1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_sof();
    sof = 1'b1; tick(); sof = 1'b0;
  endtask

  task automatic wait_req();
    while (req !== 1'b1) tick();
  endtask

  task automatic serve(input logic nonempty, input logic last);
    wait_req();
    tick();
    svc_done = 1'b1; svc_nonempty = nonempty; per_last = last;
    tick();
    svc_done = 1'b0; svc_nonempty = 1'b0; per_last = 1'b0;
  endtask

  task automatic drained(input string t);
    tick();
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  task automatic setup(input logic p, input logic c, input logic b,
                       input logic ce, input logic [1:0] r);
    per_en = p; ctl_en = c; blk_en = b; ctl_empty = ce; ratio = r;
  endtask

  initial begin
    rst_n = 1'b0; sof = 0; eof = 0; per_en = 0; ctl_en = 0; blk_en = 0;
    ctl_empty = 0; ratio = 0; svc_done = 0; svc_nonempty = 0; per_last = 0; ovr_clr = 0;
    tick(); tick();
    chk(list_sel == 2'b00, "R1 sel in reset", list_sel, 0);
    chk(req == 1'b0, "R1 req in reset", req, 0);
    tick(); rst_n = 1'b1; tick();
    chk(list_sel == 2'b00 && req == 1'b0, "R1 idle after reset", list_sel, 0);
    chk(ovr_cnt == 0 && ovr_flag == 0, "R1 overrun state", ovr_cnt, 0);

    // R2 R3 R4 R6: periodic first, then 2:1 control/bulk
    setup(1, 1, 1, 0, 2'b01);
    push(2'b01, "R2 periodic first");
    push(2'b10, "R3 control after periodic");
    push(2'b10, "R4 second control at 2:1");
    push(2'b11, "R4 bulk after two");
    push(2'b10, "R6 back to control");
    pulse_sof();
    serve(0, 1); serve(1, 0); serve(1, 0); serve(0, 0); wait_req();
    drained("R4 ratio 01 sequence");

    // R5: empty control descriptors do not count (ratio 00)
    setup(0, 1, 1, 0, 2'b00);
    push(2'b10, "R2 no periodic when disabled");
    push(2'b10, "R5 empty ctl not counted");
    push(2'b11, "R4 bulk at 1:1");
    push(2'b10, "R6 control after bulk");
    pulse_sof();
    serve(0, 0); serve(1, 0); serve(0, 0); wait_req();
    drained("R5 sequence");

    // R2: mid-frame enable change has no effect
    setup(0, 1, 1, 0, 2'b00);
    push(2'b10, "R2 frame without periodic");
    push(2'b11, "R2 mid-frame enable ignored");
    pulse_sof();
    wait_req(); per_en = 1'b1;
    serve(1, 0); wait_req();
    drained("R2 mid-frame");
    push(2'b01, "R2 enable honoured at next sof");
    pulse_sof(); wait_req();
    drained("R2 next frame");

    // R4: ratio 11 means four non-empty control before bulk
    setup(0, 1, 1, 0, 2'b11);
    for (int i = 0; i < 4; i++) push(2'b10, "R4 control at 4:1");
    push(2'b11, "R4 bulk after four");
    pulse_sof();
    for (int i = 0; i < 4; i++) serve(1, 0);
    wait_req();
    drained("R4 ratio 11 sequence");

    // R6: count restarts at start-of-frame
    setup(0, 1, 1, 0, 2'b01);
    for (int i = 0; i < 4; i++) push(2'b10, "R6 control, count restarted");
    push(2'b11, "R6 bulk after fresh count");
    pulse_sof();
    serve(1, 0); wait_req(); pulse_sof();
    serve(1, 0); serve(1, 0); wait_req();
    drained("R6 sof restart");

    // R7: empty control goes straight to bulk
    setup(1, 1, 1, 1, 2'b00);
    push(2'b01, "R7 periodic");
    push(2'b11, "R7 empty control skipped");
    push(2'b11, "R7 bulk repeats");
    pulse_sof();
    serve(0, 1); serve(0, 0); wait_req();
    drained("R7 empty control");

    // R7: control disabled
    setup(0, 0, 1, 0, 2'b00);
    push(2'b11, "R7 control disabled");
    push(2'b11, "R7 control disabled again");
    pulse_sof(); serve(0, 0); wait_req();
    drained("R7 control disabled");

    // R7: both disabled -> idle after periodic
    setup(1, 0, 0, 0, 2'b00);
    push(2'b01, "R7 periodic before idle");
    pulse_sof(); serve(0, 1);
    for (int i = 0; i < 5; i++) tick();
    chk(list_sel == 2'b00 && req == 1'b0, "R7 idle with both disabled", list_sel, 0);
    drained("R7 both disabled");

    // R8: end-of-frame without periodic pending
    eof = 1'b1; tick(); eof = 1'b0;
    chk(ovr_cnt == 0 && ovr_flag == 0, "R8 no overrun when periodic done", ovr_cnt, 0);

    // R8: overrun on pending periodic work
    setup(1, 1, 1, 0, 2'b00);
    push(2'b01, "R8 periodic pending");
    pulse_sof(); wait_req();
    eof = 1'b1; tick(); eof = 1'b0;
    chk(ovr_cnt == 1, "R8 counter incremented", ovr_cnt, 1);
    chk(ovr_flag == 1, "R8 flag set", ovr_flag, 1);
    chk(list_sel == 2'b00, "R8 idle after overrun", list_sel, 0);
    tick();
    chk(ovr_flag == 1 && req == 0, "R9 flag sticky", ovr_flag, 1);

    // R9: clear strobe
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    chk(ovr_flag == 0, "R9 flag cleared", ovr_flag, 0);
    chk(ovr_cnt == 1, "R9 counter kept on clear", ovr_cnt, 1);

    // R8: wrap modulo 4
    for (int i = 0; i < 3; i++) begin
      push(2'b01, "R8 periodic pending again");
      pulse_sof(); wait_req();
      eof = 1'b1; tick(); eof = 1'b0;
    end
    chk(ovr_cnt == 0, "R8 counter wraps", ovr_cnt, 0);

    // R9: clear and overrun together keep the flag
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    push(2'b01, "R9 periodic pending");
    pulse_sof(); wait_req();
    eof = 1'b1; ovr_clr = 1'b1; tick(); eof = 1'b0; ovr_clr = 1'b0;
    chk(ovr_flag == 1, "R9 overrun wins over clear", ovr_flag, 1);
    chk(ovr_cnt == 1, "R8 counter after wrap", ovr_cnt, 1);
    drained("R10 all requests matched");

    summary();
  end
endmodule